// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block decodes commands written by a host processor to a NOR-style flash memory model. The host issues ordinary bus writes. A synchronous strobe, derived from the chip enable, marks the cycle in which each write's address and data are sampled. Every command must be preceded by a fixed two-write unlock pattern. The write that follows the unlock carries the command code. An erase needs an arming code, a second unlock pair and a confirm code. When the decoder recognises a command, it selects what the read path returns (array, identifier or status). Program, erase and status-clear requests leave as one-cycle pulses toward the internal write controller.

The decoder is built around one state machine with six named states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for the first unlock write. |
| `ST_KEY1` | First unlock write seen. |
| `ST_KEY2` | Unlock complete; expecting the command write. |
| `ST_ERS_ARM` | Erase armed; expecting the first write of the repeated unlock. |
| `ST_ERS_KEY1` | First write of the repeated unlock seen. |
| `ST_ERS_KEY2` | Repeated unlock complete; expecting the erase confirm. |

Transitions, all taken only on an accepted write unless noted:

- `ST_IDLE` to `ST_KEY1` on AAh at 5555h.
- `ST_KEY1` to `ST_KEY2` on 55h at 2AAAh.
- `ST_KEY2` to `ST_ERS_ARM` on 80h at 5555h. Any other write in `ST_KEY2` returns to `ST_IDLE`, after issuing the command event if the code is a known one.
- `ST_ERS_ARM` to `ST_ERS_KEY1` on AAh at 5555h.
- `ST_ERS_KEY1` to `ST_ERS_KEY2` on 55h at 2AAAh.
- `ST_ERS_KEY2` to `ST_IDLE` on any write; the write issues the erase only if it is 10h at 5555h.
- Any mismatching write returns to `ST_IDLE`.
- The supply-low lockout forces `ST_IDLE` in every state, without needing a write.

The integration passes only the low 15 address bits and the low data byte to this block, because upper bits never matter to command decoding. The analog programming-voltage qualification arrives as a single write-allowed input. The write controller reports its activity on a busy input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_src` is 0 (array) and `start_prog`, `start_erase` and `clr_status` are all low.
- R2: A write is accepted only in a clock where `wr_stb`=1, `ce_n`=0, `oe_n`=1 and `hv_ok`=1. A write that is not accepted neither advances nor aborts a sequence in progress, and changes no output.
- R3: The unlock writes must be exactly AAh at address 5555h and then 55h at 2AAAh, comparing all 15 address bits.
- R4: After the unlock, a write to 5555h sets `rd_src` according to its data. F0h sets 0 (array), 90h sets 1 (identifier) and 70h sets 2 (status).
- R5: After the unlock, A0h at 5555h pulses `start_prog` and sets `rd_src` to 2.
- R6: Chip erase takes six writes: the unlock, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 10h at 5555h. The last write pulses `start_erase` and sets `rd_src` to 2.
- R7: After the unlock, 50h at 5555h pulses `clr_status` and leaves `rd_src` unchanged.
- R8: A write that does not match the expected step, or an unknown command code, returns the sequence to its start, issues nothing and leaves `rd_src` unchanged.
- R9: While `wsm_busy`=1, only the status-read command (70h) takes effect. Read/reset, identifier, program, clear and erase-confirm commands are ignored.
- R10: `vcc_low`=1 in a clock sets `rd_src` to 0, suppresses all pulses and discards any partial sequence.
- R11: `id_data` is 00C2h when `addr[0]`=0 and 006Bh when `addr[0]`=1.
- R12: A command takes effect on the clock edge that samples its final write. Pulses last exactly one cycle, and at most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write sample strobe derived from chip enable |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| hv_ok | input | 1 | Write voltage present, writes allowed |
| vcc_low | input | 1 | Supply-low lockout |
| wsm_busy | input | 1 | Program or erase in progress |
| addr | input | 15 | Low write/read address bits |
| wbyte | input | 8 | Low data byte of the write |
| rd_src | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| start_prog | output | 1 | One-cycle page program request |
| start_erase | output | 1 | One-cycle chip erase request |
| clr_status | output | 1 | One-cycle status clear request |
| id_data | output | 16 | Identifier word for the read path |

## Verification
The hardest situation to reach is one where a sequence is partly entered and then something other than a clean write intervenes. The bench places rejected writes (output enable low, write voltage absent, chip enable high) between valid unlock steps, and then finishes the sequence to show that nothing was lost. It also raises the supply-low lockout midway through an unlock. The erase path is aborted at its last step with a wrong confirm code, and every command is replayed while the busy input is held high.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_DATA_A   = 8'hAA;
    localparam logic [7:0] KEY_DATA_B   = 8'h55;
    localparam logic [7:0] OP_RESET     = 8'hF0;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_PROGRAM   = 8'hA0;
    localparam logic [7:0] OP_ERASE_ARM = 8'h80;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_CLEAR     = 8'h50;
    localparam logic [7:0] OP_ERASE_GO  = 8'h10;

    localparam logic [7:0] ID_MAKER  = 8'hC2;
    localparam logic [7:0] ID_DEVICE = 8'h6B;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_ID     = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RD_ARRAY,
        EV_RD_ID,
        EV_RD_STATUS,
        EV_PROGRAM,
        EV_ERASE,
        EV_CLEAR
    } cmd_evt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_ERS_ARM,
        ST_ERS_KEY1,
        ST_ERS_KEY2
    } seq_state_e;

endpackage

// File: rtl/wr_qualify.sv
module wr_qualify
    import flash_cmd_pkg::*;
#(
    parameter int AW = KEY_W
) (
    input  logic          wr_stb,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          hv_ok,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wbyte,
    output logic          accept,
    output logic          hit_a,
    output logic          hit_b,
    output logic [7:0]    op_byte
);

    // R2: all bus qualifiers must agree in the sampling clock
    assign accept  = wr_stb & ~ce_n & oe_n & hv_ok;
    // R3: exact compare over every address bit
    assign hit_a   = (addr == KEY_ADDR_A[AW-1:0]);
    assign hit_b   = (addr == KEY_ADDR_B[AW-1:0]);
    assign op_byte = wbyte;

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_low,
    input  logic       accept,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic [7:0] op_byte,
    output cmd_evt_e   evt
);

    seq_state_e state, state_nx;

    logic key_a_ok, key_b_ok;
    assign key_a_ok = hit_a && (op_byte == KEY_DATA_A);
    assign key_b_ok = hit_b && (op_byte == KEY_DATA_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (vcc_low) begin
            state_nx = ST_IDLE;                           // R10
        end else if (accept) begin
            unique case (state)
                ST_IDLE:     state_nx = key_a_ok ? ST_KEY1 : ST_IDLE;
                ST_KEY1:     state_nx = key_b_ok ? ST_KEY2 : ST_IDLE;
                ST_KEY2:     state_nx = (hit_a && op_byte == OP_ERASE_ARM)
                                        ? ST_ERS_ARM : ST_IDLE;
                ST_ERS_ARM:  state_nx = key_a_ok ? ST_ERS_KEY1 : ST_IDLE;
                ST_ERS_KEY1: state_nx = key_b_ok ? ST_ERS_KEY2 : ST_IDLE;
                ST_ERS_KEY2: state_nx = ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        evt = EV_NONE;
        if (accept && !vcc_low) begin
            unique case (state)
                ST_KEY2: begin
                    if (hit_a) begin
                        case (op_byte)
                            OP_RESET:   evt = EV_RD_ARRAY;
                            OP_IDENT:   evt = EV_RD_ID;
                            OP_STATUS:  evt = EV_RD_STATUS;
                            OP_PROGRAM: evt = EV_PROGRAM;
                            OP_CLEAR:   evt = EV_CLEAR;
                            default:    evt = EV_NONE;    // R8
                        endcase
                    end
                end
                ST_ERS_KEY2: begin
                    if (hit_a && op_byte == OP_ERASE_GO) evt = EV_ERASE;
                end
                default: evt = EV_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cmd_mode_reg.sv
module cmd_mode_reg
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_low,
    input  logic       wsm_busy,
    input  cmd_evt_e   evt,
    output logic [1:0] rd_src,
    output logic       start_prog,
    output logic       start_erase,
    output logic       clr_status
);

    cmd_evt_e eff;

    // R9: during an operation only the status read gets through
    always_comb begin
        eff = evt;
        if (wsm_busy && evt != EV_RD_STATUS) eff = EV_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_src      <= SRC_ARRAY;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            clr_status  <= 1'b0;
        end else begin
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            clr_status  <= 1'b0;
            if (vcc_low) begin
                rd_src <= SRC_ARRAY;
            end else begin
                unique case (eff)
                    EV_RD_ARRAY:  rd_src <= SRC_ARRAY;
                    EV_RD_ID:     rd_src <= SRC_ID;
                    EV_RD_STATUS: rd_src <= SRC_STATUS;
                    EV_PROGRAM: begin
                        rd_src     <= SRC_STATUS;
                        start_prog <= 1'b1;
                    end
                    EV_ERASE: begin
                        rd_src      <= SRC_STATUS;
                        start_erase <= 1'b1;
                    end
                    EV_CLEAR:     clr_status <= 1'b1;
                    default:      ;
                endcase
            end
        end
    end

endmodule

// File: rtl/id_mux.sv
module id_mux
    import flash_cmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          sel_dev,
    output logic [DW-1:0] id_data
);

    localparam int PAD_W = DW - 8;

    // R11: identifier bytes, zero-extended to the word width
    assign id_data = {{PAD_W{1'b0}}, (sel_dev ? ID_DEVICE : ID_MAKER)};

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int AW = KEY_W,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          hv_ok,
    input  logic          vcc_low,
    input  logic          wsm_busy,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wbyte,
    output logic [1:0]    rd_src,
    output logic          start_prog,
    output logic          start_erase,
    output logic          clr_status,
    output logic [DW-1:0] id_data
);

    logic       accept, hit_a, hit_b;
    logic [7:0] op_byte;
    cmd_evt_e   evt;

    wr_qualify #(.AW(AW)) u_qual (
        .wr_stb (wr_stb),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .hv_ok  (hv_ok),
        .addr   (addr),
        .wbyte  (wbyte),
        .accept (accept),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .op_byte(op_byte)
    );

    cmd_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .vcc_low(vcc_low),
        .accept (accept),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .op_byte(op_byte),
        .evt    (evt)
    );

    cmd_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_low    (vcc_low),
        .wsm_busy   (wsm_busy),
        .evt        (evt),
        .rd_src     (rd_src),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .clr_status (clr_status)
    );

    id_mux #(.DW(DW)) u_id (
        .sel_dev(addr[0]),
        .id_data(id_data)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       vcc_low,
    input logic       wsm_busy,
    input logic [1:0] rd_src,
    input logic       start_prog,
    input logic       start_erase,
    input logic       clr_status
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase, clr_status})); // R12

    AST_PROG_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog |-> rd_src == 2'd2); // R5

    AST_ERASE_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |-> rd_src == 2'd2); // R6

    AST_CLEAR_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && clr_status) |-> rd_src == $past(rd_src)); // R7

    AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (start_prog || start_erase || clr_status)) |-> !$past(wsm_busy)); // R9

    AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(wr_stb) && !$past(vcc_low)) |->
        ($stable(rd_src) && !start_prog && !start_erase && !clr_status)); // R2

    AST_LOCKOUT_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(vcc_low)) |->
        (rd_src == 2'd0 && !start_prog && !start_erase && !clr_status)); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .vcc_low    (vcc_low),
    .wsm_busy   (wsm_busy),
    .rd_src     (rd_src),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .clr_status (clr_status)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0, ce_n = 1'b1, oe_n = 1'b1, hv_ok = 1'b1;
    logic        vcc_low = 1'b0, wsm_busy = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wbyte = '0;
    logic [1:0]  rd_src;
    logic        start_prog, start_erase, clr_status;
    logic [15:0] id_data;

    int    checks = 0, failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .oe_n(oe_n),
        .hv_ok(hv_ok), .vcc_low(vcc_low), .wsm_busy(wsm_busy), .addr(addr),
        .wbyte(wbyte), .rd_src(rd_src), .start_prog(start_prog),
        .start_erase(start_erase), .clr_status(clr_status), .id_data(id_data)
    );

    // behavioural reference model
    int         m_step = 0;
    logic [1:0] m_src = 2'd0;
    logic       m_prog = 0, m_erase = 0, m_clr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_src = 2'd0; m_prog = 0; m_erase = 0; m_clr = 0;
        end else begin
            m_prog = 0; m_erase = 0; m_clr = 0;
            if (vcc_low) begin
                m_step = 0; m_src = 2'd0;
            end else if (wr_stb && !ce_n && oe_n && hv_ok) begin
                if (m_step == 0)
                    m_step = (addr == 15'h5555 && wbyte == 8'hAA) ? 1 : 0;
                else if (m_step == 1)
                    m_step = (addr == 15'h2AAA && wbyte == 8'h55) ? 2 : 0;
                else if (m_step == 2) begin
                    m_step = 0;
                    if (addr == 15'h5555) begin
                        if (wbyte == 8'h70) m_src = 2'd2;
                        else if (wbyte == 8'h80) m_step = 3;
                        else if (!wsm_busy) begin
                            if (wbyte == 8'hF0) m_src = 2'd0;
                            if (wbyte == 8'h90) m_src = 2'd1;
                            if (wbyte == 8'h50) m_clr = 1;
                            if (wbyte == 8'hA0) begin m_prog = 1; m_src = 2'd2; end
                        end
                    end
                end
                else if (m_step == 3)
                    m_step = (addr == 15'h5555 && wbyte == 8'hAA) ? 4 : 0;
                else if (m_step == 4)
                    m_step = (addr == 15'h2AAA && wbyte == 8'h55) ? 5 : 0;
                else begin
                    m_step = 0;
                    if (addr == 15'h5555 && wbyte == 8'h10 && !wsm_busy) begin
                        m_erase = 1; m_src = 2'd2;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, {14'd0, rd_src}, {14'd0, m_src});
            chk(cur_req, {13'd0, start_prog, start_erase, clr_status},
                {13'd0, m_prog, m_erase, m_clr});
            chk("R11", id_data, addr[0] ? 16'h006B : 16'h00C2);
        end
    end

    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input logic cen = 1'b0, input logic oen = 1'b1,
                      input logic hv = 1'b1);
        @(negedge clk);
        addr = a; wbyte = d; ce_n = cen; oe_n = oen; hv_ok = hv; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; ce_n = 1'b1; oe_n = 1'b1; hv_ok = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] code);
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
        wr(15'h5555, code);
    endtask

    task automatic erase_seq(input logic [7:0] confirm);
        cmd(8'h80);
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
        wr(15'h5555, confirm);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", {14'd0, rd_src}, 16'd0);
        chk("R1", {13'd0, start_prog, start_erase, clr_status}, 16'd0);

        cur_req = "R4";
        cmd(8'h90); chk("R4", {14'd0, rd_src}, 16'd1);
        cur_req = "R11";
        @(negedge clk); addr = 15'h0000; #1 chk("R11", id_data, 16'h00C2);
        @(negedge clk); addr = 15'h0001; #1 chk("R11", id_data, 16'h006B);
        cur_req = "R4";
        cmd(8'h70); chk("R4", {14'd0, rd_src}, 16'd2);
        cmd(8'hF0); chk("R4", {14'd0, rd_src}, 16'd0);

        cur_req = "R3";
        wr(15'h5554, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
        chk("R3", {14'd0, rd_src}, 16'd0);
        wr(15'h5555, 8'hAA); wr(15'h6AAA, 8'h55); wr(15'h5555, 8'h90);
        chk("R3", {14'd0, rd_src}, 16'd0);

        cur_req = "R5";
        cmd(8'hA0);
        chk("R5", {15'd0, start_prog}, 16'd1);
        chk("R5", {14'd0, rd_src}, 16'd2);
        cur_req = "R12";
        @(negedge clk);
        chk("R12", {15'd0, start_prog}, 16'd0);

        cur_req = "R7";
        cmd(8'h90); cmd(8'h50);
        chk("R7", {15'd0, clr_status}, 16'd1);
        chk("R7", {14'd0, rd_src}, 16'd1);

        cur_req = "R6";
        erase_seq(8'h10);
        chk("R6", {15'd0, start_erase}, 16'd1);
        chk("R6", {14'd0, rd_src}, 16'd2);

        cur_req = "R8";
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h54); wr(15'h5555, 8'h90);
        chk("R8", {14'd0, rd_src}, 16'd2);
        cmd(8'h33);
        chk("R8", {14'd0, rd_src}, 16'd2);
        erase_seq(8'h11);
        chk("R8", {15'd0, start_erase}, 16'd0);
        chk("R8", {14'd0, rd_src}, 16'd2);

        cur_req = "R2";
        wr(15'h5555, 8'hAA);
        wr(15'h1234, 8'h00, 1'b0, 1'b0, 1'b1);
        wr(15'h1234, 8'h00, 1'b0, 1'b1, 1'b0);
        wr(15'h1234, 8'h00, 1'b1, 1'b1, 1'b1);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
        chk("R2", {14'd0, rd_src}, 16'd1);
        wr(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0);
        wr(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0);
        wr(15'h5555, 8'hF0, 1'b0, 1'b1, 1'b0);
        chk("R2", {14'd0, rd_src}, 16'd1);

        cur_req = "R9";
        @(negedge clk); wsm_busy = 1'b1;
        cmd(8'hF0); chk("R9", {14'd0, rd_src}, 16'd1);
        cmd(8'hA0); chk("R9", {15'd0, start_prog}, 16'd0);
        cmd(8'h50); chk("R9", {15'd0, clr_status}, 16'd0);
        erase_seq(8'h10); chk("R9", {15'd0, start_erase}, 16'd0);
        chk("R9", {14'd0, rd_src}, 16'd1);
        cmd(8'h70); chk("R9", {14'd0, rd_src}, 16'd2);
        @(negedge clk); wsm_busy = 1'b0;

        cur_req = "R10";
        cmd(8'h90);
        wr(15'h5555, 8'hAA);
        vcc_low = 1'b1;
        @(negedge clk); vcc_low = 1'b0;
        chk("R10", {14'd0, rd_src}, 16'd0);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
        chk("R10", {14'd0, rd_src}, 16'd0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule